// File: doc/BRIEF.md
# Configuration-Space Mailbox Bridge to a 64-bit Register Bus

This block sits behind a simplified configuration access port and gives configuration software indirect access to 64-bit registers on an internal register bus. Configuration space holds three things. A 16-byte identification header sits at the bottom. A control word sits at F0h. A mailbox made of an address word (F4h), a low data word (F8h) and a high data word (FCh) completes the map. Software loads the target address, then reads or writes the two data words. Specific data-word accesses launch the internal transfer.

The configuration port works by handshake. The requester raises `cfg_req` with its command and keeps it raised until the block answers with a single-cycle `cfg_ack`, `cfg_retry` or `cfg_timeout`. An access that launches an internal transfer is stalled until the internal response returns, unless a programmable wait limit expires first. If the limit expires, the internal transfer stays outstanding, and every configuration access is answered with retry until it finishes.

The controller has three states:

- `ST_IDLE` decodes accesses. Its transition `launch` goes to `ST_WAIT`.
- `ST_WAIT` holds the launching access. Transition `answered` returns to `ST_IDLE` on a response. Transition `expired` goes to `ST_ORPHAN` when the limit runs out.
- `ST_ORPHAN` retries every access until the late response arrives. Transition `drained` then returns to `ST_IDLE`.

Top module: `cfg_msr_mailbox`

## Requirements
- R1: A read of offset 00h returns `{DEV_ID, VEN_ID}` (device in bits 31:16). Reads of 04h, 08h and 0Ch return zero. Writes into the header are acknowledged and change nothing.
- R2: After reset the control word at F0h reads bit0 (enable) = 1, bits 3:1 = 0 and bits 31:16 = `TMO_INIT`. The address word at F4h reads zero.
- R3: The address word at F4h is readable and writable. Every internal request carries its current value on `msr_addr`.
- R4: With enable set, a read of F8h issues exactly one single-cycle internal read (`msr_we`=0). The access is held without acknowledge until the response arrives. It is then acknowledged with response bits 31:0.
- R5: A read of FCh returns bits 63:32 of the most recently completed internal read. It issues no internal request.
- R6: A write of F8h only loads a holding word and is acknowledged at once with no request. A write of FCh issues an internal write with data `{FCh word, holding word}` and `msr_send_rsp`=1. That write is acknowledged only after the response arrives.
- R7: While an internal transfer is outstanding after a timeout, every configuration access gets `cfg_retry` and has no effect. After the response returns, accesses complete normally.
- R8: The held access times out if no response has been sampled within limit+1 cycles of waiting, where the limit is the value in control bits 31:16. A response sampled on the expiry cycle wins. A timed-out read returns FFFF_FFFFh. Timeout sets the sticky bit1 of the control word, and writing 1 to bit1 clears it.
- R9: A response carrying `msr_rsp_ssmi` sets sticky control bit2. A response carrying `msr_rsp_excep` sets sticky bit3. Each bit is cleared by writing 1 to it.
- R10: With enable (bit0) clear, F8h and FCh read as zero. Writes to them are ignored, and no internal request is issued. The header, control and address words keep working.
- R11: Each configuration access receives exactly one of `cfg_ack`, `cfg_retry`, `cfg_timeout`, as a pulse lasting one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_req | input | 1 | Configuration access request, held until answered |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | 8 | Configuration byte offset (dword aligned) |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_ack | output | 1 | Access completed (pulse) |
| cfg_retry | output | 1 | Access rejected, try again (pulse) |
| cfg_timeout | output | 1 | Held access abandoned after the wait limit (pulse) |
| cfg_rdata | output | 32 | Read data, valid with the completion pulse |
| msr_req | output | 1 | Internal request strobe (one cycle) |
| msr_we | output | 1 | Internal request is a write |
| msr_addr | output | 32 | Internal register address |
| msr_wdata | output | 64 | Internal write data |
| msr_send_rsp | output | 1 | Response requested for a write |
| msr_rsp_valid | input | 1 | Internal response strobe |
| msr_rsp_data | input | 64 | Internal read result |
| msr_rsp_ssmi | input | 1 | Response carries the system-management flag |
| msr_rsp_excep | input | 1 | Response carries the exception flag |

## Verification
The bench builds the block with `TMO_INIT` = 64 and a distinctive `DEV_ID`/`VEN_ID` pair. With a limit of 64, responder latencies of 2 to 10 cycles always complete. The bench then reprograms the limit to 4 at run time. That puts both sides of the expiry boundary within reach (latency 4 completes, latency 5 times out). A 20-cycle latency leaves a long orphan window in which retries are exercised.

// File: rtl/cfg_mbx_pkg.sv
package cfg_mbx_pkg;
    localparam int CFG_AW  = 8;
    localparam int CFG_DW  = 32;
    localparam int REG_DW  = 64;
    localparam int LIMIT_W = 16;

    localparam logic [CFG_AW-1:0] OFS_CTRL = 8'hF0;
    localparam logic [CFG_AW-1:0] OFS_ADDR = 8'hF4;
    localparam logic [CFG_AW-1:0] OFS_DLO  = 8'hF8;
    localparam logic [CFG_AW-1:0] OFS_DHI  = 8'hFC;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_ORPHAN
    } mbx_state_t;

    typedef enum logic [2:0] {
        AC_HEADER,
        AC_CTRL,
        AC_ADDR,
        AC_DLO,
        AC_DHI,
        AC_OTHER
    } acc_kind_t;
endpackage

// File: rtl/cfg_mbx_decode.sv
module cfg_mbx_decode
    import cfg_mbx_pkg::*;
(
    input  logic [CFG_AW-1:0] addr,
    output acc_kind_t         kind,
    output logic              hdr_id
);
    always_comb begin
        kind = AC_OTHER;
        if (addr[1:0] == 2'b00) begin
            if (addr[CFG_AW-1:4] == '0)  kind = AC_HEADER;
            else if (addr == OFS_CTRL)   kind = AC_CTRL;
            else if (addr == OFS_ADDR)   kind = AC_ADDR;
            else if (addr == OFS_DLO)    kind = AC_DLO;
            else if (addr == OFS_DHI)    kind = AC_DHI;
        end
    end

    assign hdr_id = (addr[3:2] == 2'b00);
endmodule

// File: rtl/cfg_mbx_timer.sv
module cfg_mbx_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (!run)           cnt_q <= '0;
        else if (cnt_q != limit) cnt_q <= cnt_q + 1'b1;
    end

    assign expired = run && (cnt_q == limit);
endmodule

// File: rtl/cfg_mbx_engine.sv
module cfg_mbx_engine
    import cfg_mbx_pkg::*;
#(
    parameter logic [15:0]        DEV_ID   = 16'h0001,
    parameter logic [15:0]        VEN_ID   = 16'h0001,
    parameter logic [LIMIT_W-1:0] TMO_INIT = 16'd256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_req,
    input  logic               cfg_we,
    input  logic [CFG_DW-1:0]  cfg_wdata,
    input  acc_kind_t          kind,
    input  logic               hdr_id,
    input  logic               expired,
    output logic               cfg_ack,
    output logic               cfg_retry,
    output logic               cfg_timeout,
    output logic [CFG_DW-1:0]  cfg_rdata,
    output logic               msr_req,
    output logic               msr_we,
    output logic [CFG_DW-1:0]  msr_addr,
    output logic [REG_DW-1:0]  msr_wdata,
    output logic               msr_send_rsp,
    input  logic               msr_rsp_valid,
    input  logic [REG_DW-1:0]  msr_rsp_data,
    input  logic               msr_rsp_ssmi,
    input  logic               msr_rsp_excep,
    output mbx_state_t         state_o,
    output logic               en_o,
    output logic [LIMIT_W-1:0] limit_o
);
    mbx_state_t         state_q, state_d;
    logic               take, launch, rd_pend_q;
    logic               en_q, tmo_err_q, ssmi_q, excep_q;
    logic [LIMIT_W-1:0] limit_q;
    logic [CFG_DW-1:0]  addr_q, lo_q, ctrl_word, hdr_word;
    logic [REG_DW-1:0]  data_q;

    assign take      = cfg_req && !(cfg_ack || cfg_retry || cfg_timeout);
    assign launch    = take && en_q &&
                       ((kind == AC_DLO && !cfg_we) || (kind == AC_DHI && cfg_we));
    assign ctrl_word = {limit_q, 12'd0, excep_q, ssmi_q, tmo_err_q, en_q};
    assign hdr_word  = hdr_id ? {DEV_ID, VEN_ID} : '0;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: launch, answered, expired, drained
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (launch)             state_d = ST_WAIT;
            ST_WAIT:   if (msr_rsp_valid)      state_d = ST_IDLE;
                       else if (expired)       state_d = ST_ORPHAN;
            ST_ORPHAN: if (msr_rsp_valid)      state_d = ST_IDLE;
            default:                           state_d = ST_IDLE;
        endcase
    end

    // outputs and register file
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_ack      <= 1'b0;
            cfg_retry    <= 1'b0;
            cfg_timeout  <= 1'b0;
            cfg_rdata    <= '0;
            msr_req      <= 1'b0;
            msr_we       <= 1'b0;
            msr_addr     <= '0;
            msr_wdata    <= '0;
            msr_send_rsp <= 1'b0;
            rd_pend_q    <= 1'b0;
            en_q         <= 1'b1;
            tmo_err_q    <= 1'b0;
            ssmi_q       <= 1'b0;
            excep_q      <= 1'b0;
            limit_q      <= TMO_INIT;
            addr_q       <= '0;
            lo_q         <= '0;
            data_q       <= '0;
        end else begin
            cfg_ack     <= 1'b0;
            cfg_retry   <= 1'b0;
            cfg_timeout <= 1'b0;
            msr_req     <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (take) begin
                    cfg_rdata <= '0;
                    if (launch) begin
                        msr_req      <= 1'b1;
                        msr_we       <= cfg_we;
                        msr_addr     <= addr_q;
                        msr_wdata    <= {cfg_wdata, lo_q};
                        msr_send_rsp <= cfg_we;
                        rd_pend_q    <= !cfg_we;
                    end else begin
                        cfg_ack <= 1'b1;
                        unique case (kind)
                            AC_HEADER: if (!cfg_we) cfg_rdata <= hdr_word;
                            AC_CTRL: begin
                                if (cfg_we) begin
                                    en_q      <= cfg_wdata[0];
                                    tmo_err_q <= tmo_err_q & ~cfg_wdata[1];
                                    ssmi_q    <= ssmi_q    & ~cfg_wdata[2];
                                    excep_q   <= excep_q   & ~cfg_wdata[3];
                                    limit_q   <= cfg_wdata[31:16];
                                end else begin
                                    cfg_rdata <= ctrl_word;
                                end
                            end
                            AC_ADDR: begin
                                if (cfg_we) addr_q    <= cfg_wdata;
                                else        cfg_rdata <= addr_q;
                            end
                            AC_DLO: if (cfg_we && en_q) lo_q <= cfg_wdata;
                            AC_DHI: if (!cfg_we && en_q) cfg_rdata <= data_q[63:32];
                            default: ;
                        endcase
                    end
                end
                ST_WAIT: begin
                    if (msr_rsp_valid) begin
                        cfg_ack <= 1'b1;
                        ssmi_q  <= ssmi_q  | msr_rsp_ssmi;
                        excep_q <= excep_q | msr_rsp_excep;
                        if (rd_pend_q) begin
                            data_q    <= msr_rsp_data;
                            cfg_rdata <= msr_rsp_data[31:0];
                        end else begin
                            cfg_rdata <= '0;
                        end
                    end else if (expired) begin
                        cfg_timeout <= 1'b1;
                        tmo_err_q   <= 1'b1;
                        cfg_rdata   <= rd_pend_q ? '1 : '0;
                    end
                end
                ST_ORPHAN: begin
                    if (msr_rsp_valid) begin
                        ssmi_q  <= ssmi_q  | msr_rsp_ssmi;
                        excep_q <= excep_q | msr_rsp_excep;
                    end
                    if (take) begin
                        cfg_retry <= 1'b1;
                        cfg_rdata <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    assign state_o = state_q;
    assign en_o    = en_q;
    assign limit_o = limit_q;
endmodule

// File: rtl/cfg_msr_mailbox.sv
module cfg_msr_mailbox
    import cfg_mbx_pkg::*;
#(
    parameter logic [15:0]        DEV_ID   = 16'h0001,
    parameter logic [15:0]        VEN_ID   = 16'h0001,
    parameter logic [LIMIT_W-1:0] TMO_INIT = 16'd256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_req,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output logic              cfg_ack,
    output logic              cfg_retry,
    output logic              cfg_timeout,
    output logic [CFG_DW-1:0] cfg_rdata,
    output logic              msr_req,
    output logic              msr_we,
    output logic [CFG_DW-1:0] msr_addr,
    output logic [REG_DW-1:0] msr_wdata,
    output logic              msr_send_rsp,
    input  logic              msr_rsp_valid,
    input  logic [REG_DW-1:0] msr_rsp_data,
    input  logic              msr_rsp_ssmi,
    input  logic              msr_rsp_excep
);
    acc_kind_t          kind;
    logic               hdr_id;
    logic               expired;
    mbx_state_t         mbx_state;
    logic               mbx_en;
    logic [LIMIT_W-1:0] limit;

    cfg_mbx_decode u_dec (
        .addr   (cfg_addr),
        .kind   (kind),
        .hdr_id (hdr_id)
    );

    cfg_mbx_timer #(.W(LIMIT_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (mbx_state == ST_WAIT),
        .limit   (limit),
        .expired (expired)
    );

    cfg_mbx_engine #(
        .DEV_ID   (DEV_ID),
        .VEN_ID   (VEN_ID),
        .TMO_INIT (TMO_INIT)
    ) u_eng (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_req       (cfg_req),
        .cfg_we        (cfg_we),
        .cfg_wdata     (cfg_wdata),
        .kind          (kind),
        .hdr_id        (hdr_id),
        .expired       (expired),
        .cfg_ack       (cfg_ack),
        .cfg_retry     (cfg_retry),
        .cfg_timeout   (cfg_timeout),
        .cfg_rdata     (cfg_rdata),
        .msr_req       (msr_req),
        .msr_we        (msr_we),
        .msr_addr      (msr_addr),
        .msr_wdata     (msr_wdata),
        .msr_send_rsp  (msr_send_rsp),
        .msr_rsp_valid (msr_rsp_valid),
        .msr_rsp_data  (msr_rsp_data),
        .msr_rsp_ssmi  (msr_rsp_ssmi),
        .msr_rsp_excep (msr_rsp_excep),
        .state_o       (mbx_state),
        .en_o          (mbx_en),
        .limit_o       (limit)
    );
endmodule

// File: rtl/cfg_msr_mailbox_chk.sv
module cfg_msr_mailbox_chk
    import cfg_mbx_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_we,
    input logic        cfg_ack,
    input logic        cfg_retry,
    input logic        cfg_timeout,
    input logic [31:0] cfg_rdata,
    input logic        msr_req,
    input logic        msr_we,
    input logic        msr_send_rsp,
    input logic        msr_rsp_valid,
    input mbx_state_t  st,
    input logic        en
);
    logic done;
    assign done = cfg_ack || cfg_retry || cfg_timeout;

    a_r11_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cfg_ack, cfg_retry, cfg_timeout}));

    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r6_send_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_req && msr_we) |-> msr_send_rsp);

    a_r4_req_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        msr_req |=> !msr_req);

    a_r4_held: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT && !msr_rsp_valid) |=> !cfg_ack);

    a_r7_retry_orphan: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_retry |-> ($past(st) == ST_ORPHAN));

    a_r8_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_timeout && !cfg_we) |-> (cfg_rdata == 32'hFFFF_FFFF));

    a_r10_gate: assert property (@(posedge clk) disable iff (!rst_n)
        msr_req |-> $past(en));
endmodule

bind cfg_msr_mailbox cfg_msr_mailbox_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_we        (cfg_we),
    .cfg_ack       (cfg_ack),
    .cfg_retry     (cfg_retry),
    .cfg_timeout   (cfg_timeout),
    .cfg_rdata     (cfg_rdata),
    .msr_req       (msr_req),
    .msr_we        (msr_we),
    .msr_send_rsp  (msr_send_rsp),
    .msr_rsp_valid (msr_rsp_valid),
    .st            (mbx_state),
    .en            (mbx_en)
);

// File: tb/cfg_msr_mailbox_tb_top.sv
`timescale 1ns/1ps
module cfg_msr_mailbox_tb_top;
    localparam logic [15:0] T_DEV = 16'h5A3C;
    localparam logic [15:0] T_VEN = 16'h1F2E;
    localparam logic [15:0] T_LIM = 16'd64;
    localparam int K_ACK = 0, K_RETRY = 1, K_TMO = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_req = 1'b0, cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        cfg_ack, cfg_retry, cfg_timeout;
    logic [31:0] cfg_rdata;
    logic        msr_req, msr_we, msr_send_rsp;
    logic [31:0] msr_addr;
    logic [63:0] msr_wdata;
    logic        msr_rsp_valid = 1'b0, msr_rsp_ssmi = 1'b0, msr_rsp_excep = 1'b0;
    logic [63:0] msr_rsp_data = '0;

    always #2 clk = ~clk;

    cfg_msr_mailbox #(.DEV_ID(T_DEV), .VEN_ID(T_VEN), .TMO_INIT(T_LIM)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_ack(cfg_ack),
        .cfg_retry(cfg_retry), .cfg_timeout(cfg_timeout), .cfg_rdata(cfg_rdata),
        .msr_req(msr_req), .msr_we(msr_we), .msr_addr(msr_addr),
        .msr_wdata(msr_wdata), .msr_send_rsp(msr_send_rsp),
        .msr_rsp_valid(msr_rsp_valid), .msr_rsp_data(msr_rsp_data),
        .msr_rsp_ssmi(msr_rsp_ssmi), .msr_rsp_excep(msr_rsp_excep));

    int n_chk = 0, n_fail = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] model(input logic [31:0] a);
        return {a ^ 32'hC3C3_0000, a + 32'h1000_0000};
    endfunction

    // responder model
    int          rsp_lat = 2;
    bit          nxt_ssmi = 0, nxt_excep = 0;
    int          req_cnt = 0;
    logic        last_we, last_sr;
    logic [31:0] last_addr;
    logic [63:0] last_wdata;

    initial forever begin
        @(negedge clk);
        if (rst_n && msr_req) begin
            req_cnt++;
            last_we = msr_we; last_addr = msr_addr;
            last_wdata = msr_wdata; last_sr = msr_send_rsp;
            repeat (rsp_lat) @(negedge clk);
            msr_rsp_data  = model(last_addr);
            msr_rsp_ssmi  = nxt_ssmi;
            msr_rsp_excep = nxt_excep;
            msr_rsp_valid = 1'b1;
            @(negedge clk);
            msr_rsp_valid = 1'b0; msr_rsp_ssmi = 1'b0; msr_rsp_excep = 1'b0;
            nxt_ssmi = 0; nxt_excep = 0;
        end
    end

    // scoreboard
    int          q_kind[$];
    bit          q_chk[$];
    logic [31:0] q_data[$];
    string       q_tag[$];

    initial forever begin
        @(negedge clk);
        if (rst_n && (cfg_ack || cfg_retry || cfg_timeout)) begin
            int k;
            k = cfg_ack ? K_ACK : (cfg_retry ? K_RETRY : K_TMO);
            if (q_kind.size() == 0) begin
                check(0, "R11", "unexpected completion", 64'(k), 64'hFFFF);
            end else begin
                int ek; bit ec; logic [31:0] ed; string et;
                ek = q_kind.pop_front(); ec = q_chk.pop_front();
                ed = q_data.pop_front(); et = q_tag.pop_front();
                check(k == ek, et, "completion kind", 64'(k), 64'(ek));
                if (ec) check(cfg_rdata == ed, et, "read data", 64'(cfg_rdata), 64'(ed));
            end
        end
    end

    task automatic access(input bit we, input logic [7:0] a, input logic [31:0] d,
                          input int ek, input bit ec, input logic [31:0] ed,
                          input string tag);
        int n;
        q_kind.push_back(ek); q_chk.push_back(ec);
        q_data.push_back(ed); q_tag.push_back(tag);
        @(negedge clk);
        cfg_req = 1'b1; cfg_we = we; cfg_addr = a; cfg_wdata = d;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!(cfg_ack || cfg_retry || cfg_timeout) && n < 1000);
        if (n >= 1000) check(0, tag, "access hung", 64'(n), 64'd0);
        cfg_req = 1'b0; cfg_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, input int ek, input logic [31:0] ed,
                      input string tag);
        access(1'b0, a, 32'h0, ek, 1'b1, ed, tag);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input int ek,
                      input string tag);
        access(1'b1, a, d, ek, 1'b0, 32'h0, tag);
    endtask

    task automatic finish_run();
        repeat (4) @(negedge clk);
        check(q_kind.size() == 0, "R11", "pending completions", 64'(q_kind.size()), 64'd0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        check(0, "WDOG", "watchdog expired", 64'd0, 64'd1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int c0;
        logic [31:0] lim_ctrl;
        logic [31:0] last_rd;
        lim_ctrl = {T_LIM, 16'h0001};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2 reset state
        rd(8'hF0, K_ACK, lim_ctrl, "R2");
        rd(8'hF4, K_ACK, 32'h0, "R2");
        // R1 header
        rd(8'h00, K_ACK, {T_DEV, T_VEN}, "R1");
        rd(8'h08, K_ACK, 32'h0, "R1");
        wr(8'h00, 32'hFFFF_FFFF, K_ACK, "R1");
        rd(8'h00, K_ACK, {T_DEV, T_VEN}, "R1");
        // R3 address word
        wr(8'hF4, 32'h0000_1234, K_ACK, "R3");
        rd(8'hF4, K_ACK, 32'h0000_1234, "R3");
        // R4 / R5 read
        rsp_lat = 3; c0 = req_cnt;
        rd(8'hF8, K_ACK, model(32'h1234)[31:0], "R4");
        check(req_cnt == c0 + 1, "R4", "one read request", 64'(req_cnt), 64'(c0 + 1));
        check(last_we == 1'b0 && last_addr == 32'h1234, "R3", "request addr/dir",
              {31'b0, last_we, last_addr}, 64'h1234);
        c0 = req_cnt;
        rd(8'hFC, K_ACK, model(32'h1234)[63:32], "R5");
        check(req_cnt == c0, "R5", "no request on high read", 64'(req_cnt), 64'(c0));
        rsp_lat = 10;
        wr(8'hF4, 32'h0BAD_0F00, K_ACK, "R3");
        rd(8'hF8, K_ACK, model(32'h0BAD_0F00)[31:0], "R4");
        rd(8'hFC, K_ACK, model(32'h0BAD_0F00)[63:32], "R5");
        // R6 write
        c0 = req_cnt;
        wr(8'hF8, 32'hDEAD_BEEF, K_ACK, "R6");
        check(req_cnt == c0, "R6", "no request on low write", 64'(req_cnt), 64'(c0));
        rsp_lat = 5;
        wr(8'hFC, 32'h0123_4567, K_ACK, "R6");
        check(req_cnt == c0 + 1 && last_we && last_sr, "R6", "write request flags",
              {62'b0, last_we, last_sr}, 64'h3);
        check(last_wdata == 64'h0123_4567_DEAD_BEEF, "R6", "write data",
              last_wdata, 64'h0123_4567_DEAD_BEEF);
        // R9 flags
        rsp_lat = 2; nxt_ssmi = 1;
        rd(8'hF8, K_ACK, model(32'h0BAD_0F00)[31:0], "R9");
        rd(8'hF0, K_ACK, lim_ctrl | 32'h4, "R9");
        wr(8'hF0, lim_ctrl | 32'h4, K_ACK, "R9");
        rd(8'hF0, K_ACK, lim_ctrl, "R9");
        nxt_excep = 1;
        wr(8'hFC, 32'h0, K_ACK, "R9");
        rd(8'hF0, K_ACK, lim_ctrl | 32'h8, "R9");
        wr(8'hF0, lim_ctrl | 32'h8, K_ACK, "R9");
        rd(8'hF0, K_ACK, lim_ctrl, "R9");
        // R8 timeout boundary with limit 4
        lim_ctrl = 32'h0004_0001;
        wr(8'hF0, lim_ctrl, K_ACK, "R8");
        wr(8'hF4, 32'h0000_2000, K_ACK, "R3");
        rsp_lat = 4;
        rd(8'hF8, K_ACK, model(32'h2000)[31:0], "R8");
        last_rd = 32'h2000;
        rd(8'hF0, K_ACK, lim_ctrl, "R8");
        wr(8'hF4, 32'h0000_3000, K_ACK, "R3");
        rsp_lat = 5;
        rd(8'hF8, K_TMO, 32'hFFFF_FFFF, "R8");
        repeat (10) @(negedge clk);
        rd(8'hF0, K_ACK, lim_ctrl | 32'h2, "R8");
        wr(8'hF0, lim_ctrl | 32'h2, K_ACK, "R8");
        rd(8'hF0, K_ACK, lim_ctrl, "R8");
        // R7 orphan window
        rsp_lat = 20;
        rd(8'hF8, K_TMO, 32'hFFFF_FFFF, "R8");
        rd(8'hF0, K_RETRY, 32'h0, "R7");
        wr(8'hF4, 32'h0000_9999, K_RETRY, "R7");
        repeat (30) @(negedge clk);
        rd(8'hF4, K_ACK, 32'h0000_3000, "R7");
        rd(8'hFC, K_ACK, model(last_rd)[63:32], "R7");
        wr(8'hF0, lim_ctrl | 32'h2, K_ACK, "R8");
        // R10 disabled
        wr(8'hF0, 32'h0004_0000, K_ACK, "R10");
        rd(8'hF0, K_ACK, 32'h0004_0000, "R10");
        c0 = req_cnt;
        rd(8'hF8, K_ACK, 32'h0, "R10");
        rd(8'hFC, K_ACK, 32'h0, "R10");
        wr(8'hF8, 32'h1111_1111, K_ACK, "R10");
        wr(8'hFC, 32'h2222_2222, K_ACK, "R10");
        check(req_cnt == c0, "R10", "no request while disabled", 64'(req_cnt), 64'(c0));
        rd(8'h00, K_ACK, {T_DEV, T_VEN}, "R10");
        wr(8'hF4, 32'h0000_4000, K_ACK, "R10");
        rd(8'hF4, K_ACK, 32'h0000_4000, "R10");
        wr(8'hF0, lim_ctrl, K_ACK, "R10");
        rd(8'hFC, K_ACK, model(last_rd)[63:32], "R10");
        rsp_lat = 2;
        wr(8'hFC, 32'hABCD_0000, K_ACK, "R10");
        check(last_wdata == 64'hABCD_0000_DEAD_BEEF, "R10", "holding word kept",
              last_wdata, 64'hABCD_0000_DEAD_BEEF);
        check(last_addr == 32'h4000, "R3", "address used", 64'(last_addr), 64'h4000);
        finish_run();
    end
endmodule